// File: doc/BRIEF.md
# Clocked Set-Reset Flag With Asynchronous Request Conditioning

This block accepts two asynchronous requests, one that sets a flag and one that clears it, and keeps the flag in a register that changes only on the rising edge of the system clock. Each request goes through its own conditioning path before it can reach the flag. A parameter selects one of three paths for each request. The capture path has a register that any request pulse sets at once, so pulses narrower than a clock period are held until the clock domain has seen them. The sync path is a plain multi-flop synchronizer, meant for requests that stay high longer than one clock period. The direct path has no added stages and is for requests that already come from the same clock.

The flag is a two-state machine with the states FLAG_LOW and FLAG_HIGH. The ASSERT transition (FLAG_LOW to FLAG_HIGH) occurs when the conditioned set is high and the conditioned clear is low. The RELEASE transition (FLAG_HIGH to FLAG_LOW) occurs when the conditioned clear is high. The conditioned clear takes priority over the conditioned set. A registered strobe marks the first cycle of each ASSERT. Another registered strobe marks the first cycle of each RELEASE. Downstream logic uses the flag as a level and uses the strobes as one-cycle events.

Top module: `srsync_flag`

## Requirements
- R1: When `srst_i` is high at a clock edge, `flag_o`, `rise_o` and `fall_o` are all 0 after that edge. Synchronous reset also clears every synchronizer stage.
- R2: On a sync path with the default two stages, a request that first becomes high between two edges is sampled at the next edge, called edge 1. The flag responds at edge 3 and not before.
- R3: On a capture path, a request pulse that rises and falls between two clock edges still acts on the flag at edge 3 after the pulse.
- R4: On a sync path, a request pulse that rises and falls between two clock edges has no effect on the flag.
- R5: A capture register clears at the first edge at which its synchronized copy is high and the raw request is low. After that clear, the old pulse cannot act on the flag again when a later clear request arrives.
- R6: When the conditioned set and the conditioned clear are both high at an edge, the flag is 0 after that edge.
- R7: On a direct path, a request that is high at an edge acts on the flag at that same edge.
- R8: `rise_o` is 1 for exactly the one cycle in which `flag_o` has just gone from 0 to 1. A set request that arrives while the flag is already 1 raises no strobe.
- R9: `fall_o` is 1 for exactly the one cycle in which `flag_o` has just gone from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; every change of the flag happens on its rising edge |
| srst_i | input | 1 | Synchronous reset, active high |
| set_req_i | input | 1 | Set request, asynchronous unless its path is direct |
| clr_req_i | input | 1 | Clear request, asynchronous unless its path is direct |
| flag_o | output | 1 | The flag; 1 while in FLAG_HIGH |
| rise_o | output | 1 | One-cycle strobe on ASSERT |
| fall_o | output | 1 | One-cycle strobe on RELEASE |

## Verification
The bench places a narrow pulse between two clock edges on a capture path and on a sync path. A design that confuses the two paths either loses a valid set or acts on a clear it should miss. The bench sets both requests together and checks that the flag does not rise. If the set took priority, the flag would rise and `rise_o` would fire. The bench checks the flag on the edge before it may change and on the edge where it must change. This catches a synchronizer with a missing or extra stage. After the flag is cleared, the bench watches it for several cycles. A capture register that never releases would set the flag again.

// File: rtl/srsync_pkg.sv
package srsync_pkg;

    // Conditioning applied to one request before it reaches the flag
    typedef enum logic [1:0] {
        PATH_DIRECT  = 2'd0,
        PATH_SYNC    = 2'd1,
        PATH_CAPTURE = 2'd2
    } req_path_e;

    typedef enum logic {
        FLAG_LOW  = 1'b0,
        FLAG_HIGH = 1'b1
    } flag_state_e;

endpackage

// File: rtl/srsync_capture.sv
module srsync_capture (
    input  logic clk_i,
    input  logic srst_i,
    input  logic req_i,
    input  logic seen_i,
    output logic cap_o
);

    logic cap_q;

    // Raw request sets the register at once; cleared only on a clock edge
    always_ff @(posedge clk_i or posedge req_i) begin
        if (req_i) begin
            cap_q <= 1'b1;
        end else if (srst_i || seen_i) begin
            cap_q <= 1'b0;
        end
    end

    assign cap_o = cap_q;

    // R3
    cap_hold_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        (cap_q && !seen_i) |=> cap_q);

    // R5
    cap_release_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        (cap_q && seen_i && !req_i) |=> (!cap_q || req_i));

endmodule

// File: rtl/srsync_sync.sv
module srsync_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic srst_i,
    input  logic d_i,
    output logic q_o
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i) begin
                if (srst_i) chain_q <= '0;
                else        chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk_i) begin
                if (srst_i) chain_q <= '0;
                else        chain_q <= {chain_q[LAST-1:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[LAST];

endmodule

// File: rtl/srsync_req_path.sv
module srsync_req_path
    import srsync_pkg::*;
#(
    parameter req_path_e PATH   = PATH_SYNC,
    parameter int        STAGES = 2
) (
    input  logic clk_i,
    input  logic srst_i,
    input  logic req_i,
    output logic req_s_o
);

    generate
        if (PATH == PATH_CAPTURE) begin : g_capture
            logic cap;
            logic synced;
            srsync_capture u_cap (
                .clk_i  (clk_i),
                .srst_i (srst_i),
                .req_i  (req_i),
                .seen_i (synced),
                .cap_o  (cap)
            );
            srsync_sync #(.STAGES(STAGES)) u_sync (
                .clk_i  (clk_i),
                .srst_i (srst_i),
                .d_i    (cap),
                .q_o    (synced)
            );
            assign req_s_o = synced;
        end else if (PATH == PATH_SYNC) begin : g_sync
            srsync_sync #(.STAGES(STAGES)) u_sync (
                .clk_i  (clk_i),
                .srst_i (srst_i),
                .d_i    (req_i),
                .q_o    (req_s_o)
            );
        end else begin : g_direct
            assign req_s_o = req_i;
        end
    endgenerate

endmodule

// File: rtl/srsync_flag_fsm.sv
module srsync_flag_fsm
    import srsync_pkg::*;
(
    input  logic clk_i,
    input  logic srst_i,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o,
    output logic rise_o,
    output logic fall_o
);

    flag_state_e state_q;
    flag_state_e state_d;
    logic        rise_q;
    logic        fall_q;

    // State register
    always_ff @(posedge clk_i) begin
        if (srst_i) state_q <= FLAG_LOW;
        else        state_q <= state_d;
    end

    // Transitions: clear has priority over set
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_LOW: begin
                if (set_i && !clr_i) state_d = FLAG_HIGH;   // ASSERT
            end
            FLAG_HIGH: begin
                if (clr_i) state_d = FLAG_LOW;              // RELEASE
            end
            default: state_d = FLAG_LOW;
        endcase
    end

    // Output strobes, registered so they line up with the new flag value
    always_ff @(posedge clk_i) begin
        if (srst_i) begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            rise_q <= (state_q == FLAG_LOW)  && (state_d == FLAG_HIGH);
            fall_q <= (state_q == FLAG_HIGH) && (state_d == FLAG_LOW);
        end
    end

    assign flag_o = (state_q == FLAG_HIGH);
    assign rise_o = rise_q;
    assign fall_o = fall_q;

    // R6
    clear_wins_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        (set_i && clr_i) |=> !flag_o);

    // R8
    rise_edge_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        rise_o |-> (flag_o && !$past(flag_o)));

    // R9
    fall_edge_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        fall_o |-> (!flag_o && $past(flag_o)));

    // R8
    strobe_excl_chk: assert property (@(posedge clk_i) disable iff (srst_i)
        $onehot0({rise_o, fall_o}));

endmodule

// File: rtl/srsync_flag.sv
module srsync_flag
    import srsync_pkg::*;
#(
    parameter req_path_e SET_PATH    = PATH_CAPTURE,
    parameter req_path_e CLR_PATH    = PATH_SYNC,
    parameter int        SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic srst_i,
    input  logic set_req_i,
    input  logic clr_req_i,
    output logic flag_o,
    output logic rise_o,
    output logic fall_o
);

    logic set_s;
    logic clr_s;

    srsync_req_path #(.PATH(SET_PATH), .STAGES(SYNC_STAGES)) u_set_path (
        .clk_i   (clk_i),
        .srst_i  (srst_i),
        .req_i   (set_req_i),
        .req_s_o (set_s)
    );

    srsync_req_path #(.PATH(CLR_PATH), .STAGES(SYNC_STAGES)) u_clr_path (
        .clk_i   (clk_i),
        .srst_i  (srst_i),
        .req_i   (clr_req_i),
        .req_s_o (clr_s)
    );

    srsync_flag_fsm u_fsm (
        .clk_i  (clk_i),
        .srst_i (srst_i),
        .set_i  (set_s),
        .clr_i  (clr_s),
        .flag_o (flag_o),
        .rise_o (rise_o),
        .fall_o (fall_o)
    );

endmodule

// File: tb/tb_srsync_flag.sv
module tb_srsync_flag;
    import srsync_pkg::*;

    logic clk = 1'b0;
    logic srst = 1'b1;
    logic set_req = 1'b0, clr_req = 1'b0;
    logic d_set = 1'b0, d_clr = 1'b0;
    logic flag, rise, fall;
    logic d_flag, d_rise, d_fall;
    int   checks = 0;
    int   failures = 0;

    always #2 clk = ~clk;   // 250 MHz

    srsync_flag #(.SET_PATH(PATH_CAPTURE), .CLR_PATH(PATH_SYNC), .SYNC_STAGES(2)) dut (
        .clk_i(clk), .srst_i(srst), .set_req_i(set_req), .clr_req_i(clr_req),
        .flag_o(flag), .rise_o(rise), .fall_o(fall));

    srsync_flag #(.SET_PATH(PATH_DIRECT), .CLR_PATH(PATH_DIRECT), .SYNC_STAGES(2)) dut_direct (
        .clk_i(clk), .srst_i(srst), .set_req_i(d_set), .clr_req_i(d_clr),
        .flag_o(d_flag), .rise_o(d_rise), .fall_o(d_fall));

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Advance to 1 ns after the next rising edge
    task automatic edge1();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic t_reset();
        srst = 1'b1;
        edge1();
        edge1();
        chk("R1", "flag", flag, 0);
        chk("R1", "rise", rise, 0);
        chk("R1", "fall", fall, 0);
        chk("R1", "direct flag", d_flag, 0);
        srst = 1'b0;
        edge1();
    endtask

    // R3 narrow set pulse on capture path, then R8 strobe width
    task automatic t_capture_narrow();
        set_req = 1'b1;
        #1 set_req = 1'b0;
        edge1();
        edge1();
        chk("R3", "flag before edge 3", flag, 0);
        edge1();
        chk("R3", "flag at edge 3", flag, 1);
        chk("R8", "rise at edge 3", rise, 1);
        edge1();
        chk("R8", "rise one cycle", rise, 0);
        chk("R8", "flag held", flag, 1);
    endtask

    // R8 set while already high: no strobe
    task automatic t_set_while_high();
        int seen = 0;
        set_req = 1'b1;
        #1 set_req = 1'b0;
        for (int i = 0; i < 6; i++) begin
            edge1();
            if (rise) seen++;
        end
        chk("R8", "rise count while high", seen, 0);
    endtask

    // R4 narrow clear on sync path ignored
    task automatic t_sync_narrow();
        int seen = 0;
        clr_req = 1'b1;
        #1 clr_req = 1'b0;
        for (int i = 0; i < 6; i++) begin
            edge1();
            if (fall) seen++;
        end
        chk("R4", "flag after narrow clear", flag, 1);
        chk("R4", "fall count", seen, 0);
    endtask

    // R2 latency on sync path; R9 fall strobe; R5 capture released
    task automatic t_sync_clear();
        int again = 0;
        clr_req = 1'b1;
        edge1();
        edge1();
        chk("R2", "flag before edge 3", flag, 1);
        edge1();
        chk("R2", "flag at edge 3", flag, 0);
        chk("R9", "fall at edge 3", fall, 1);
        clr_req = 1'b0;
        edge1();
        chk("R9", "fall one cycle", fall, 0);
        for (int i = 0; i < 8; i++) begin
            edge1();
            if (flag || rise) again++;
        end
        chk("R5", "flag re-set after release", again, 0);
    endtask

    // R6 both requests together: clear wins
    task automatic t_both();
        int up = 0;
        set_req = 1'b1;
        clr_req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            edge1();
            if (flag || rise) up++;
        end
        set_req = 1'b0;
        for (int i = 0; i < 6; i++) begin
            edge1();
            if (flag || rise) up++;
        end
        clr_req = 1'b0;
        for (int i = 0; i < 5; i++) begin
            edge1();
            if (flag || rise) up++;
        end
        chk("R6", "flag high cycles with both requests", up, 0);
    endtask

    // R7 direct path acts on the same edge; R6 on direct path
    task automatic t_direct();
        d_set = 1'b1;
        edge1();
        chk("R7", "direct flag after one edge", d_flag, 1);
        chk("R8", "direct rise", d_rise, 1);
        d_set = 1'b0;
        d_clr = 1'b1;
        edge1();
        chk("R7", "direct clear after one edge", d_flag, 0);
        chk("R9", "direct fall", d_fall, 1);
        d_set = 1'b1;
        edge1();
        chk("R6", "direct both high", d_flag, 0);
        d_set = 1'b0;
        d_clr = 1'b0;
        edge1();
    endtask

    // R1 reset while flag high
    task automatic t_reset_high();
        set_req = 1'b1;
        repeat (4) edge1();
        set_req = 1'b0;
        repeat (4) edge1();
        chk("R1", "flag set before reset", flag, 1);
        srst = 1'b1;
        edge1();
        chk("R1", "flag after reset", flag, 0);
        chk("R1", "fall after reset", fall, 0);
        srst = 1'b0;
        edge1();
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_capture_narrow();
        t_set_while_high();
        t_sync_narrow();
        t_sync_clear();
        t_both();
        t_direct();
        t_reset_high();
        summary();
        $finish;
    end

endmodule